// File: doc/BRIEF.md
# Three-Level Carrier-Comparison Gate Generator

This block drives the switches of a three-phase, three-level inverter that clamps each output to the midpoint of its DC bus. Each phase leg has four series switches, numbered S1 (top) to S4 (bottom). The block compares a signed reference for each phase with two triangular carriers. The two carriers are stacked one above the other, run in phase, and are both derived from one up/down counter. The comparison gives two switch demands per phase, one per complementary switch pair. A timer on each pair inserts a gap in which both switches are off. An interlock makes sure each leg only steps between adjacent output levels.

Each leg ends in one of three states:
- P: the output is tied to the positive rail.
- O: the output is clamped to the midpoint.
- N: the output is tied to the negative rail.

The control loop supplies the three references as 16-bit two's-complement samples. Full scale is ±32767 (±1). The triangle's half period is set in clock cycles, and the length of the switching gap is also set in clock cycles. The block outputs four gate bits per phase and a 2-bit state code that software or a protection block can watch.

Top module: `npc_pdpwm`

## Requirements
- R1: After reset the carrier counter rises from 0 (the valley) one step per clock to `half_period` (the peak) and falls back, so a carrier period lasts 2*`half_period` clocks. At count c the upper carrier is c*32767/`half_period` and the lower carrier is that value minus 32767.
- R2: The upper pair demands S1 when the held reference is strictly above the upper carrier, or equals +32767. Otherwise it demands S3.
- R3: The lower pair demands S2 when the held reference is at or above the lower carrier, unless the reference equals -32767. Otherwise it demands S4.
- R4: Gate bit 0 is S1, bit 1 is S2, bit 2 is S3 and bit 3 is S4. The state code is 2'b01 when S1 and S2 are on (P), 2'b10 when S3 and S4 are on (N), and 2'b00 otherwise (O).
- R5: S1 and S3 are never on together, and S2 and S4 are never on together.
- R6: When a pair's demand changes, both of its gates go off and the incoming gate turns on `dead_cycles` clocks later. With `dead_cycles` = 0 the two gates swap on the same edge. Gates lag the demand by one clock.
- R7: A phase never goes from P to N, or from N to P, in one clock. S1 turns on only while S2 is on, and S4 turns on only while S3 is on. A P-to-N move therefore spends 2*`dead_cycles`+1 clocks in O.
- R8: A reference input is captured only on edges where the counter is at its valley or its peak. Changes between those edges have no effect.
- R9: A reference of -32768 is treated as -32767. A reference held at +32767 keeps state P for the whole period, and one held at -32767 keeps state N.
- R10: A synchronous reset turns off all twelve gates, gives state O on every phase, clears the held references and puts the counter at its valley.
- R11: While either pair of a phase has both gates off, the state code of that phase reads O.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| ref_a | input | 16 | Phase A reference, signed, ±32767 full scale |
| ref_b | input | 16 | Phase B reference, signed |
| ref_c | input | 16 | Phase C reference, signed |
| half_period | input | 16 | Carrier half period in clocks (at least 1) |
| dead_cycles | input | 8 | Switching gap in clocks, 0 to 255 |
| gate_a | output | 4 | Phase A gates {S4,S3,S2,S1} |
| gate_b | output | 4 | Phase B gates {S4,S3,S2,S1} |
| gate_c | output | 4 | Phase C gates {S4,S3,S2,S1} |
| state_a | output | 2 | Phase A state code (P=01, O=00, N=10) |
| state_b | output | 2 | Phase B state code |
| state_c | output | 2 | Phase C state code |

## Verification
The hardest case to reach is a reference that jumps from one rail to the other, because only that case drives both switch pairs to change together. The stimulus first holds phase A at +32767 until it settles in P. It then applies -32768 and counts the O clocks seen before N appears. Whether a reference is captured at all depends on where the counter sits, and the ports give no view of the counter. The stimulus therefore counts edges from reset release and pulses the reference strictly between two sampling edges. Duty checks compare gate on-times over one full carrier period with totals computed from the carrier equations, with the dead-time loss subtracted.

// File: rtl/npc_pdpwm.sv
`timescale 1ns/1ps
module npc_pdpwm #(
  parameter int W  = 16,
  parameter int PW = 16,
  parameter int DW = 8
) (
  input  logic                clk,
  input  logic                rst,
  input  logic signed [W-1:0] ref_a,
  input  logic signed [W-1:0] ref_b,
  input  logic signed [W-1:0] ref_c,
  input  logic [PW-1:0]       half_period,
  input  logic [DW-1:0]       dead_cycles,
  output logic [3:0]          gate_a,
  output logic [3:0]          gate_b,
  output logic [3:0]          gate_c,
  output logic [1:0]          state_a,
  output logic [1:0]          state_b,
  output logic [1:0]          state_c
);
  localparam int MW  = W + PW + 2;
  localparam int FSI = 2**(W-1) - 1;
  localparam logic signed [W-1:0]  FSW = W'(FSI);
  localparam logic signed [W-1:0]  MOST_NEG = {1'b1, {(W-1){1'b0}}};
  localparam logic signed [MW-1:0] FSM = MW'(FSI);

  logic [PW-1:0] cnt, hp;
  logic          rising;
  logic          extreme;
  logic signed [MW-1:0] carrier_s, full_s;

  assign hp        = (half_period == '0) ? PW'(1) : half_period;
  assign extreme   = (cnt == '0) || (cnt >= hp);
  assign carrier_s = $signed({{(MW-PW){1'b0}}, cnt}) * FSM;
  assign full_s    = $signed({{(MW-PW){1'b0}}, hp}) * FSM;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt    <= '0;
      rising <= 1'b1;
    end else if (rising) begin
      if (cnt >= hp) begin
        rising <= 1'b0;
        cnt    <= cnt - 1'b1;
      end else begin
        cnt <= cnt + 1'b1;
      end
    end else if (cnt == '0) begin
      rising <= 1'b1;
      cnt    <= cnt + 1'b1;
    end else begin
      cnt <= cnt - 1'b1;
    end
  end

  logic signed [W-1:0] refs [3];
  logic [3:0]          gates [3];
  logic [1:0]          codes [3];

  assign refs[0] = ref_a;
  assign refs[1] = ref_b;
  assign refs[2] = ref_c;

  for (genvar p = 0; p < 3; p++) begin : g_phase
    logic signed [W-1:0]  held;
    logic signed [W-1:0]  clamped;
    logic signed [MW-1:0] ref_s;
    logic [1:0]           hi, lo, want;
    logic [DW-1:0]        tmr [2];

    assign clamped = (refs[p] == MOST_NEG) ? -FSW : refs[p];
    assign ref_s   = MW'(held) * $signed({{(MW-PW){1'b0}}, hp});

    assign want[0] = ((held == FSW) || (ref_s > carrier_s)) && hi[1];
    assign want[1] = ((held != -FSW) && (ref_s + full_s >= carrier_s)) || !lo[0];

    always_ff @(posedge clk) begin
      if (rst)          held <= '0;
      else if (extreme) held <= clamped;
    end

    always_ff @(posedge clk) begin
      for (int k = 0; k < 2; k++) begin
        if (rst) begin
          hi[k]  <= 1'b0;
          lo[k]  <= 1'b0;
          tmr[k] <= '0;
        end else if (tmr[k] != '0) begin
          tmr[k] <= tmr[k] - 1'b1;
          if (tmr[k] == DW'(1)) begin
            hi[k] <= want[k];
            lo[k] <= !want[k];
          end
        end else if (hi[k] != want[k] || lo[k] == want[k]) begin
          if (dead_cycles == '0) begin
            hi[k] <= want[k];
            lo[k] <= !want[k];
          end else begin
            hi[k]  <= 1'b0;
            lo[k]  <= 1'b0;
            tmr[k] <= dead_cycles;
          end
        end
      end
    end

    assign gates[p] = {lo[1], lo[0], hi[1], hi[0]};
    assign codes[p] = (hi[0] && hi[1]) ? 2'b01 :
                      (lo[0] && lo[1]) ? 2'b10 : 2'b00;
  end

  assign gate_a  = gates[0];
  assign gate_b  = gates[1];
  assign gate_c  = gates[2];
  assign state_a = codes[0];
  assign state_b = codes[1];
  assign state_c = codes[2];
endmodule

module npc_pdpwm_props (
  input logic       clk,
  input logic       rst,
  input logic [3:0] gate_a,
  input logic [3:0] gate_b,
  input logic [3:0] gate_c,
  input logic [1:0] state_a,
  input logic [1:0] state_b,
  input logic [1:0] state_c,
  input logic [7:0] dead_cycles
);
  logic [3:0] g [3];
  logic [1:0] s [3];
  assign g[0] = gate_a;
  assign g[1] = gate_b;
  assign g[2] = gate_c;
  assign s[0] = state_a;
  assign s[1] = state_b;
  assign s[2] = state_c;

  for (genvar p = 0; p < 3; p++) begin : g_chk
    assert_pair_exclusive_R5: assert property (@(posedge clk) disable iff (rst)
      !(g[p][0] && g[p][2]) && !(g[p][1] && g[p][3]));
    assert_no_p_to_n_R7: assert property (@(posedge clk) disable iff (rst)
      (s[p] == 2'b01) |=> (s[p] != 2'b10));
    assert_no_n_to_p_R7: assert property (@(posedge clk) disable iff (rst)
      (s[p] == 2'b10) |=> (s[p] != 2'b01));
    assert_gap_upper_R6: assert property (@(posedge clk) disable iff (rst)
      (dead_cycles != 8'd0 && $fell(g[p][0])) |-> !g[p][2]);
    assert_gap_lower_R6: assert property (@(posedge clk) disable iff (rst)
      (dead_cycles != 8'd0 && $fell(g[p][1])) |-> !g[p][3]);
    assert_reset_off_R10: assert property (@(posedge clk) disable iff (rst)
      $past(rst) |-> (g[p] == 4'd0 && s[p] == 2'b00));
  end
endmodule

bind npc_pdpwm npc_pdpwm_props u_props (
  .clk(clk), .rst(rst),
  .gate_a(gate_a), .gate_b(gate_b), .gate_c(gate_c),
  .state_a(state_a), .state_b(state_b), .state_c(state_c),
  .dead_cycles(dead_cycles)
);

// File: tb/npc_pdpwm_test.sv
`timescale 1ns/1ps
module npc_pdpwm_test;
  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic               rst = 1'b1;
  logic signed [15:0] ref_a = '0, ref_b = '0, ref_c = '0;
  logic [15:0]        half_period = 16'd16;
  logic [7:0]         dead_cycles = '0;
  logic [3:0]         gate_a, gate_b, gate_c;
  logic [1:0]         state_a, state_b, state_c;

  npc_pdpwm uut (
    .clk(clk), .rst(rst), .ref_a(ref_a), .ref_b(ref_b), .ref_c(ref_c),
    .half_period(half_period), .dead_cycles(dead_cycles),
    .gate_a(gate_a), .gate_b(gate_b), .gate_c(gate_c),
    .state_a(state_a), .state_b(state_b), .state_c(state_c)
  );

  int checks = 0, errors = 0;
  int expq[$];
  string tagq[$];
  bit req = 0, ack = 0, done = 0;
  int win = 0;
  int jumps = 0;

  logic [3:0] g [3];
  logic [1:0] s [3];
  assign g[0] = gate_a;
  assign g[1] = gate_b;
  assign g[2] = gate_c;
  assign s[0] = state_a;
  assign s[1] = state_b;
  assign s[2] = state_c;

  task automatic chk(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", tag, act, exp);
    end
  endtask

  function automatic int clampr(int r);
    return (r < -32767) ? -32767 : r;
  endfunction

  function automatic int raw_u(int r, int hp);
    int acc = 0;
    if (r == 32767) return 2 * hp;
    for (int c = 0; c <= hp; c++)
      if (real'(r) > real'(c) * 32767.0 / real'(hp)) acc += (c == 0 || c == hp) ? 1 : 2;
    return acc;
  endfunction

  function automatic int raw_l(int r, int hp);
    int acc = 0;
    if (r == -32767) return 0;
    for (int c = 0; c <= hp; c++)
      if (real'(r) >= real'(c) * 32767.0 / real'(hp) - 32767.0) acc += (c == 0 || c == hp) ? 1 : 2;
    return acc;
  endfunction

  task automatic push_phase(int rin, int hp, int d, string ph);
    int r = clampr(rin);
    int per = 2 * hp;
    int ru = raw_u(r, hp), rl = raw_l(r, hp);
    bit tu = ru > 0 && ru < per, tl = rl > 0 && rl < per;
    int s1 = tu ? ru - d : ru, s3 = tu ? per - ru - d : per - ru;
    int s2 = tl ? rl - d : rl, s4 = tl ? per - rl - d : per - rl;
    string sat = (rin >= 32767 || rin <= -32767) ? " R9" : "";
    expq.push_back(s1); tagq.push_back({"R2 R6 S1 on-time ", ph, sat});
    expq.push_back(s2); tagq.push_back({"R3 R6 S2 on-time ", ph, sat});
    expq.push_back(s3); tagq.push_back({"R2 R6 S3 on-time ", ph, sat});
    expq.push_back(s4); tagq.push_back({"R3 R6 S4 on-time ", ph, sat});
    expq.push_back(rl == per ? s1 : 0); tagq.push_back({"R4 P cycles ", ph, sat});
    expq.push_back(ru == 0 ? s4 : 0);   tagq.push_back({"R4 N cycles ", ph, sat});
  endtask

  task automatic do_reset(int hp, int d, int ra, int rb, int rc);
    @(negedge clk);
    rst = 1'b1;
    half_period = 16'(hp);
    dead_cycles = 8'(d);
    ref_a = 16'(ra); ref_b = 16'(rb); ref_c = 16'(rc);
    repeat (2) @(negedge clk);
    chk("R10 gates off in reset", {20'd0, gate_a, gate_b, gate_c}, 0);
    chk("R10 state O in reset", {26'd0, state_a, state_b, state_c}, 0);
    rst = 1'b0;
  endtask

  task automatic measure(int hp, int d, int ra, int rb, int rc);
    repeat (4 * hp + 3 * d + 12) @(negedge clk);
    push_phase(ra, hp, d, "phase A");
    push_phase(rb, hp, d, "phase B");
    push_phase(rc, hp, d, "phase C");
    win = 2 * hp;
    req = 1'b1;
    wait (ack);
    req = 1'b0;
    wait (!ack);
  endtask

  // monitor: measures one carrier period and pops the expected totals
  initial begin
    forever begin
      int tot [3][6];
      int overlap, mism, deadbad;
      wait (req);
      overlap = 0; mism = 0; deadbad = 0;
      for (int p = 0; p < 3; p++) for (int k = 0; k < 6; k++) tot[p][k] = 0;
      repeat (win) begin
        @(negedge clk);
        for (int p = 0; p < 3; p++) begin
          logic [1:0] want_code;
          for (int k = 0; k < 4; k++) tot[p][k] += int'(g[p][k]);
          tot[p][4] += int'(s[p] == 2'b01);
          tot[p][5] += int'(s[p] == 2'b10);
          if ((g[p][0] && g[p][2]) || (g[p][1] && g[p][3])) overlap++;
          want_code = (g[p][0] && g[p][1]) ? 2'b01 : (g[p][2] && g[p][3]) ? 2'b10 : 2'b00;
          if (s[p] != want_code) mism++;
          if (((!g[p][0] && !g[p][2]) || (!g[p][1] && !g[p][3])) && s[p] != 2'b00) deadbad++;
        end
      end
      for (int p = 0; p < 3; p++)
        for (int k = 0; k < 6; k++) chk(tagq.pop_front(), tot[p][k], expq.pop_front());
      chk("R5 pair overlap cycles", overlap, 0);
      chk("R4 state code vs gates", mism, 0);
      chk("R11 code O during gap", deadbad, 0);
      ack = 1'b1;
      wait (!req);
      ack = 1'b0;
    end
  end

  // direct rail-to-rail jump counter
  initial begin
    logic [1:0] prev [3];
    for (int p = 0; p < 3; p++) prev[p] = 2'b00;
    forever begin
      @(negedge clk);
      for (int p = 0; p < 3; p++) begin
        if (!rst && ((prev[p] == 2'b01 && s[p] == 2'b10) || (prev[p] == 2'b10 && s[p] == 2'b01))) jumps++;
        prev[p] = s[p];
      end
    end
  end

  initial begin
    #(150000 * 5);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired actual 1 expected 0");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    int s1sum;
    int orun;
    bit seen_n;

    // R8 and R1: capture only at valley/peak, counted in edges from reset
    do_reset(16, 0, 0, 0, 0);
    s1sum = 0;
    for (int k = 0; k < 50; k++) begin
      @(negedge clk);
      if (k < 48) s1sum += int'(gate_a[0]);
      if (k == 48) chk("R8 S1 still off right after peak capture", int'(gate_a[0]), 0);
      if (k == 49) chk("R8 R1 S1 on one edge after peak at edge 48", int'(gate_a[0]), 1);
      if (k == 2)  ref_a = 16'sd32767;
      if (k == 12) ref_a = 16'sd0;
      if (k == 40) ref_a = 16'sd32767;
    end
    chk("R8 pulse between sampling edges ignored", s1sum, 0);

    do_reset(32, 3, 16000, -12000, 0);
    measure(32, 3, 16000, -12000, 0);

    do_reset(50, 0, 32767, -32768, -32767);
    measure(50, 0, 32767, -32768, -32767);

    do_reset(20, 2, -5000, 30000, 3000);
    measure(20, 2, -5000, 30000, 3000);

    do_reset(8, 0, 32766, -32766, 16384);
    measure(8, 0, 32766, -32766, 16384);

    do_reset(600, 255, 8000, 32767, -32767);
    measure(600, 255, 8000, 32767, -32767);

    // R7: rail-to-rail move passes through O for 2*D+1 clocks
    do_reset(10, 4, 32767, 0, 0);
    measure(10, 4, 32767, 0, 0);
    @(negedge clk);
    ref_a = -16'sd32768;
    orun = 0;
    seen_n = 0;
    for (int i = 0; i < 200 && !seen_n; i++) begin
      @(negedge clk);
      if (state_a == 2'b00) orun++;
      else if (state_a == 2'b10) seen_n = 1;
    end
    chk("R7 N reached after P", int'(seen_n), 1);
    chk("R7 O clocks between P and N", orun, 9);
    measure(10, 4, -32768, 0, 0);

    chk("R7 direct P/N jumps over run", jumps, 0);

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule